// File: doc/BRIEF.md
# Hub Repeater Port Router

This block is the traffic router at the centre of a full/low-speed USB hub repeater. It sits between one upstream port and a set of downstream ports. Each port's pair of data lines arrives already sampled once per full-speed bit time as a two-bit pair {D+, D-}. The router decides, bit by bit, which way traffic flows. When the host starts a packet, the router repeats the upstream line to every enabled full-speed port. Low-speed ports receive traffic only after a preamble PID. When an enabled downstream device starts a packet and the host is silent, that device's line is converted to full-speed polarity and repeated out of the upstream port.

The router also classifies each attached device as full or low speed. It does this from which data line sits high while the port is still disabled. It runs a frame timer that counts full-speed bit times and is brought back to zero whenever a start-of-frame PID arrives from the host.

The controller has four states:
- ST_IDLE: nothing is connected.
- ST_DN_FS: host traffic goes to the full-speed ports.
- ST_DN_LS: host traffic goes to all enabled ports, after a preamble.
- ST_UP: one downstream port is repeated upstream.

The transitions are:
- ST_IDLE to ST_DN_FS when the upstream line shows K.
- ST_IDLE to ST_UP when an enabled downstream port shows K and the upstream line does not.
- ST_DN_FS to ST_DN_LS on a preamble PID.
- ST_DN_FS or ST_DN_LS to ST_IDLE on an upstream end of packet.
- ST_UP to ST_IDLE on the owning port's end of packet.

Top module: `hub_repeater_router`

## Requirements
- R1: Line pairs are {D+,D-}, with 00 meaning SE0. On the upstream side and on full-speed ports, 10 is J and 01 is K; on low-speed ports the two non-zero codes are swapped. While a port is disabled and its line is not SE0, its `port_ls` bit takes the value 1 if the line is 01 and 0 if it is 10. Otherwise the bit holds. It is 0 after reset.
- R2: From idle, an upstream K starts a downstream connection. Each enabled full-speed port then drives the upstream line one clock later. A disabled port always has its driver off and drives 00.
- R3: Without a preamble PID, no low-speed port is ever driven.
- R4: A preamble is a SYNC followed by PID byte 0x3C. Bits are sent LSB first in NRZI, where a 0 bit is a line change and a 1 bit is no change. After a preamble, the upstream symbols from the first one after the last PID bit onward are repeated to the enabled low-speed ports, with the pair swapped. The first of these appears two clocks after the last PID bit, which is within four bit times. The full-speed ports keep repeating throughout.
- R5: A downstream connection ends when the upstream line shows J after at least two SE0 bits. That J is still repeated, and every downstream driver is off on the next clock.
- R6: From idle, if the upstream line is not K, the lowest-numbered enabled downstream port showing K in its own polarity becomes the owner. Its line, converted to full-speed polarity, drives the upstream port one clock later. All other downstream ports are ignored while it owns the connection.
- R7: An upstream connection ends with the same end-of-packet rule applied to the owner's converted line. The final J is repeated, and the upstream driver is off on the next clock.
- R8: When the upstream line and a downstream port show K in the same idle clock, the downstream direction wins. The upstream and downstream drivers are never on together.
- R9: `frame_cnt` is 0 after reset. It counts up by one each clock and wraps from FRAME_BITS-1 to 0.
- R10: A start-of-frame PID (0xA5 after SYNC) received from upstream makes `frame_cnt` 0 on the clock after its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one cycle per full-speed bit |
| rst_n | input | 1 | Active-low reset |
| us_rx | input | 2 | Upstream received line pair {D+,D-} |
| us_tx | output | 2 | Upstream transmitted line pair |
| us_tx_en | output | 1 | Upstream driver enable |
| ds_rx | input | 2*NPORT | Downstream received line pairs, port p at bits [2p+1:2p] |
| port_en | input | NPORT | Per-port enable |
| ds_tx | output | 2*NPORT | Downstream transmitted line pairs |
| ds_tx_en | output | NPORT | Per-port driver enable |
| port_ls | output | NPORT | Per-port low-speed classification |
| frame_cnt | output | $clog2(FRAME_BITS) | Frame timer in bit times |

## Verification
The downstream direction is swept over every port-enable mask with a mixed speed assignment. Each mask is sent once with a plain full-speed packet and once with a preamble followed by a slow packet. The first sweep shows that low-speed ports stay dark; the second shows that they join on exactly the expected clock with swapped polarity and leave at the end of packet. All sixteen speed patterns are classified. The upstream direction is tried from each port in turn, from two ports starting together, from a disabled port, and against a simultaneous host start. These cases separate ownership order, polarity conversion and direction priority. The frame timer is realigned by a start-of-frame packet and then followed through one full wrap.

// File: rtl/hub_rpt_pkg.sv
package hub_rpt_pkg;

    typedef logic [1:0] line_t;

    localparam line_t LN_SE0 = 2'b00;
    localparam line_t LN_J   = 2'b10;
    localparam line_t LN_K   = 2'b01;

    localparam logic [7:0] SYNC_BITS = 8'h80;
    localparam logic [7:0] PID_PRE   = 8'h3C;
    localparam logic [7:0] PID_SOF   = 8'hA5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DN_FS,
        ST_DN_LS,
        ST_UP
    } rpt_state_t;

    // Convert between a port's own polarity and full-speed polarity.
    function automatic line_t to_fs(input line_t l, input logic ls);
        return ls ? {l[0], l[1]} : l;
    endfunction

endpackage

// File: rtl/hub_eop_watch.sv
module hub_eop_watch
    import hub_rpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line,
    output logic  eop
);
    logic [1:0] se0_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se0_run <= '0;
        end else if (line == LN_SE0) begin
            if (se0_run != 2'd3) se0_run <= se0_run + 2'd1;
        end else begin
            se0_run <= '0;
        end
    end

    assign eop = (line == LN_J) && (se0_run >= 2'd2);
endmodule

// File: rtl/hub_pid_watch.sv
module hub_pid_watch
    import hub_rpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line,
    input  logic  run,
    output logic  pre_hit,
    output logic  sof_hit
);
    localparam int NBITS = 16;
    localparam int CW    = $clog2(NBITS + 1);

    line_t             prev;
    logic [NBITS-1:0]  sr;
    logic [CW-1:0]     cnt;
    logic              bit_now;
    logic [NBITS-1:0]  sr_next;
    logic              last_bit;

    assign bit_now  = (line == prev);
    assign sr_next  = {bit_now, sr[NBITS-1:1]};
    assign last_bit = run && (cnt == CW'(NBITS - 1));
    assign pre_hit  = last_bit && (sr_next == {PID_PRE, SYNC_BITS});
    assign sof_hit  = last_bit && (sr_next == {PID_SOF, SYNC_BITS});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= LN_J;
            sr   <= '0;
            cnt  <= '0;
        end else begin
            prev <= line;
            if (!run) begin
                cnt <= '0;
            end else if (cnt != CW'(NBITS)) begin
                sr  <= sr_next;
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hub_speed_class.sv
module hub_speed_class
    import hub_rpt_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NPORT-1:0] ds_rx,
    input  logic [NPORT-1:0]   port_en,
    output logic [NPORT-1:0]   port_ls
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_ls[p] <= 1'b0;
            end else if (!port_en[p] && ds_rx[2*p +: 2] != LN_SE0) begin
                port_ls[p] <= (ds_rx[2*p +: 2] == 2'b01);
            end
        end
    end
endmodule

// File: rtl/hub_frame_timer.sv
module hub_frame_timer #(
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    output logic [FW-1:0] cnt
);
    localparam logic [FW-1:0] LAST = FW'(FRAME_BITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (sof)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hub_repeater_router.sv
module hub_repeater_router
    import hub_rpt_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS),
    localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         us_rx,
    output logic [1:0]         us_tx,
    output logic               us_tx_en,
    input  logic [2*NPORT-1:0] ds_rx,
    input  logic [NPORT-1:0]   port_en,
    output logic [2*NPORT-1:0] ds_tx,
    output logic [NPORT-1:0]   ds_tx_en,
    output logic [NPORT-1:0]   port_ls,
    output logic [FW-1:0]      frame_cnt
);
    rpt_state_t      state, state_nx;
    logic [IW-1:0]   owner;
    logic [IW-1:0]   cand_idx;
    logic            cand_any;
    line_t           own_line;
    logic            us_k;
    logic            start_dn, start_up;
    logic            fs_drive, ls_drive, up_drive;
    logic            us_eop, own_eop;
    logic            pid_run, pre_hit, sof_hit;

    hub_speed_class #(.NPORT(NPORT)) u_speed (
        .clk(clk), .rst_n(rst_n), .ds_rx(ds_rx),
        .port_en(port_en), .port_ls(port_ls)
    );

    hub_eop_watch u_us_eop (
        .clk(clk), .rst_n(rst_n), .line(us_rx), .eop(us_eop)
    );

    hub_eop_watch u_own_eop (
        .clk(clk), .rst_n(rst_n), .line(own_line), .eop(own_eop)
    );

    hub_pid_watch u_pid (
        .clk(clk), .rst_n(rst_n), .line(us_rx), .run(pid_run),
        .pre_hit(pre_hit), .sof_hit(sof_hit)
    );

    hub_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .sof(sof_hit), .cnt(frame_cnt)
    );

    // Lowest-numbered enabled port showing K in its own polarity.
    always_comb begin
        cand_any = 1'b0;
        cand_idx = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (port_en[p] && to_fs(ds_rx[2*p +: 2], port_ls[p]) == LN_K) begin
                cand_any = 1'b1;
                cand_idx = IW'(p);
            end
        end
    end

    assign own_line = to_fs(ds_rx[2*owner +: 2], port_ls[owner]);
    assign us_k     = (us_rx == LN_K);
    assign start_dn = (state == ST_IDLE) && us_k;
    assign start_up = (state == ST_IDLE) && !us_k && cand_any;
    assign fs_drive = start_dn || (state == ST_DN_FS) || (state == ST_DN_LS);
    assign ls_drive = (state == ST_DN_LS);
    assign up_drive = start_up || (state == ST_UP);
    assign pid_run  = start_dn || (state == ST_DN_FS);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_dn)      state_nx = ST_DN_FS;
                else if (start_up) state_nx = ST_UP;
            end
            ST_DN_FS: begin
                if (us_eop)        state_nx = ST_IDLE;
                else if (pre_hit)  state_nx = ST_DN_LS;
            end
            ST_DN_LS: begin
                if (us_eop)        state_nx = ST_IDLE;
            end
            ST_UP: begin
                if (own_eop)       state_nx = ST_IDLE;
            end
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register and owner capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
        end else begin
            state <= state_nx;
            if (start_up) owner <= cand_idx;
        end
    end

    // Registered line drivers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_tx    <= '0;
            ds_tx_en <= '0;
            us_tx    <= LN_SE0;
            us_tx_en <= 1'b0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (port_en[p] && (port_ls[p] ? ls_drive : fs_drive)) begin
                    ds_tx_en[p]      <= 1'b1;
                    ds_tx[2*p +: 2]  <= to_fs(us_rx, port_ls[p]);
                end else begin
                    ds_tx_en[p]      <= 1'b0;
                    ds_tx[2*p +: 2]  <= LN_SE0;
                end
            end
            us_tx_en <= up_drive;
            if (start_up)             us_tx <= LN_K;
            else if (state == ST_UP)  us_tx <= own_line;
            else                      us_tx <= LN_SE0;
        end
    end
endmodule

// File: rtl/hub_repeater_router_chk.sv
module hub_repeater_router_chk #(
    parameter int NPORT      = 4,
    parameter int FRAME_BITS = 12000,
    localparam int FW = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] port_en,
    input logic [NPORT-1:0] port_ls,
    input logic [NPORT-1:0] ds_tx_en,
    input logic             us_tx_en,
    input logic             pre_hit,
    input logic             sof_hit,
    input logic [FW-1:0]    frame_cnt
);
    localparam logic [FW-1:0] LAST = FW'(FRAME_BITS - 1);

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            ds_tx_en[p] |-> $past(port_en[p]));

        a_r4_ls_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ds_tx_en[p]) && port_ls[p]) |-> $past(pre_hit, 2));
    end

    a_r8_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(us_tx_en && (|ds_tx_en)));

    a_r9_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_hit && frame_cnt != LAST) |=> frame_cnt == $past(frame_cnt) + 1'b1);

    a_r10_sof_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sof_hit |=> frame_cnt == '0);
endmodule

bind hub_repeater_router hub_repeater_router_chk #(
    .NPORT(NPORT), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_ls(port_ls),
    .ds_tx_en(ds_tx_en), .us_tx_en(us_tx_en), .pre_hit(pre_hit),
    .sof_hit(sof_hit), .frame_cnt(frame_cnt)
);

// File: tb/test_hub_repeater_router.sv
module test_hub_repeater_router;
    localparam int NPORT = 4;
    localparam int FRAME = 12000;
    localparam int FW    = $clog2(FRAME);
    localparam logic [1:0] J = 2'b10, K = 2'b01, Z = 2'b00;

    logic               clk = 0;
    logic               rst_n = 0;
    logic [1:0]         us_rx = J;
    logic [1:0]         us_tx;
    logic               us_tx_en;
    logic [2*NPORT-1:0] ds_rx = '0;
    logic [NPORT-1:0]   port_en = '0;
    logic [2*NPORT-1:0] ds_tx;
    logic [NPORT-1:0]   ds_tx_en;
    logic [NPORT-1:0]   port_ls;
    logic [FW-1:0]      frame_cnt;

    int checks = 0;
    int fails  = 0;
    logic [NPORT-1:0] ls_pat;
    logic [1:0] cur;
    logic [1:0] dsn [NPORT];

    hub_repeater_router #(.NPORT(NPORT), .FRAME_BITS(FRAME)) i_hub_repeater_router (
        .clk(clk), .rst_n(rst_n), .us_rx(us_rx), .us_tx(us_tx), .us_tx_en(us_tx_en),
        .ds_rx(ds_rx), .port_en(port_en), .ds_tx(ds_tx), .ds_tx_en(ds_tx_en),
        .port_ls(port_ls), .frame_cnt(frame_cnt)
    );

    always #4 clk = ~clk;

    function automatic logic [1:0] swp(input logic [1:0] l, input logic ls);
        return ls ? {l[0], l[1]} : l;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one upstream bit and check every downstream driver one clock later.
    task automatic dbit(input logic [1:0] l, input bit conn, input bit lsx, input string req);
        logic [NPORT-1:0]   een;
        logic [2*NPORT-1:0] etx;
        us_rx = l;
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) begin
            een[p] = conn && port_en[p] && (ls_pat[p] ? lsx : 1'b1);
            etx[2*p +: 2] = een[p] ? swp(l, ls_pat[p]) : Z;
        end
        check({us_tx_en, ds_tx_en, ds_tx} == {1'b0, een, etx}, req,
              32'({us_tx_en, ds_tx_en, ds_tx}), 32'({1'b0, een, etx}));
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        for (int i = 0; i < 8; i++) begin
            if (!b[i]) cur = (cur == J) ? K : J;
            dbit(cur, 1'b1, 1'b0, req);
        end
    endtask

    task automatic drive_ds();
        for (int p = 0; p < NPORT; p++) ds_rx[2*p +: 2] = swp(dsn[p], ls_pat[p]);
    endtask

    // Drive downstream lines (normalised) and check the upstream driver.
    task automatic ustep(input bit een, input logic [1:0] el, input string req);
        drive_ds();
        us_rx = J;
        @(negedge clk);
        check({us_tx_en, us_tx, ds_tx_en} == {een, een ? el : Z, 4'b0}, req,
              32'({us_tx_en, us_tx, ds_tx_en}), 32'({een, een ? el : Z, 4'b0}));
    endtask

    task automatic classify(input logic [NPORT-1:0] pat);
        port_en = '0;
        for (int p = 0; p < NPORT; p++) ds_rx[2*p +: 2] = pat[p] ? 2'b01 : 2'b10;
        @(negedge clk);
        check(port_ls == pat, "R1 classify", 32'(port_ls), 32'(pat));
        ls_pat = pat;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({us_tx_en, ds_tx_en, port_ls} == 0 && frame_cnt == 0, "R9 reset",
              32'({us_tx_en, ds_tx_en, port_ls, frame_cnt}), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: every speed pattern, then SE0 while disabled leaves it held.
        for (int pat = 0; pat < 16; pat++) classify(4'(pat));
        ds_rx = '0;
        @(negedge clk);
        check(port_ls == 4'hF, "R1 hold on SE0", 32'(port_ls), 32'hF);
        classify(4'b0110);

        // R2 R3 R5: plain full-speed packet over every enable mask.
        for (int m = 0; m < 16; m++) begin
            port_en = 4'(m);
            cur = J;
            send_byte(8'h80, "R2 sync");
            send_byte(8'hC3, "R3 no preamble");
            dbit(Z, 1, 0, "R5 eop se0");
            dbit(Z, 1, 0, "R5 eop se0");
            dbit(J, 1, 0, "R5 eop j");
            dbit(J, 0, 0, "R5 torn down");
        end

        // R4 R5: preamble, then a slow packet, over every enable mask.
        for (int m = 0; m < 16; m++) begin
            port_en = 4'(m);
            cur = J;
            send_byte(8'h80, "R4 sync");
            send_byte(8'h3C, "R4 pre pid");
            for (int i = 0; i < 4; i++) dbit(J, 1, 1, "R4 ls enabled");
            for (int i = 0; i < 8; i++) dbit(K, 1, 1, "R4 ls data k");
            for (int i = 0; i < 8; i++) dbit(J, 1, 1, "R4 ls data j");
            for (int i = 0; i < 16; i++) dbit(Z, 1, 1, "R5 ls eop se0");
            dbit(J, 1, 1, "R5 ls eop j");
            dbit(J, 0, 0, "R5 ls torn down");
        end

        // R6 R7: each port in turn repeated upstream.
        port_en = 4'hF;
        for (int s = 0; s < NPORT; s++) begin
            for (int p = 0; p < NPORT; p++) dsn[p] = J;
            dsn[s] = K; ustep(1, K, "R6 start");
            dsn[s] = J; ustep(1, J, "R6 data");
            dsn[(s + 1) % NPORT] = K;
            dsn[s] = K; ustep(1, K, "R6 other ignored");
            dsn[(s + 1) % NPORT] = J;
            dsn[s] = Z; ustep(1, Z, "R7 se0");
            ustep(1, Z, "R7 se0");
            dsn[s] = J; ustep(1, J, "R7 eop j");
            ustep(0, Z, "R7 torn down");
        end

        // R6: two ports together, lowest wins.
        for (int p = 0; p < NPORT; p++) dsn[p] = J;
        dsn[1] = K; dsn[3] = K; ustep(1, K, "R6 priority");
        dsn[1] = J;             ustep(1, J, "R6 priority owner");
        dsn[3] = J; dsn[1] = Z; ustep(1, Z, "R7 se0");
        ustep(1, Z, "R7 se0");
        dsn[1] = J; ustep(1, J, "R7 eop j");
        ustep(0, Z, "R7 torn down");

        // R6: a disabled port is never repeated.
        port_en = 4'b1011;
        dsn[2] = K; ustep(0, Z, "R6 disabled ignored");
        ustep(0, Z, "R6 disabled ignored");
        dsn[2] = J; ustep(0, Z, "R6 disabled ignored");

        // R8: simultaneous starts, downstream wins.
        port_en = 4'hF;
        dsn[0] = K; drive_ds();
        dbit(K, 1, 0, "R8 downstream wins");
        dsn[0] = J; drive_ds();
        dbit(J, 1, 0, "R8 downstream holds");
        dbit(Z, 1, 0, "R8 se0");
        dbit(Z, 1, 0, "R8 se0");
        dbit(J, 1, 0, "R8 eop j");
        dbit(J, 0, 0, "R8 torn down");

        // R10 R9: start-of-frame realigns, then a full wrap.
        cur = J;
        send_byte(8'h80, "R10 sync");
        send_byte(8'hA5, "R10 sof pid");
        check(frame_cnt == 0, "R10 sof zero", 32'(frame_cnt), 32'h0);
        dbit(Z, 1, 0, "R10 eop"); dbit(Z, 1, 0, "R10 eop"); dbit(J, 1, 0, "R10 eop");
        check(frame_cnt == 3, "R9 count", 32'(frame_cnt), 32'h3);
        repeat (FRAME - 4) @(negedge clk);
        check(frame_cnt == FW'(FRAME - 1), "R9 last", 32'(frame_cnt), 32'(FRAME - 1));
        @(negedge clk);
        check(frame_cnt == 0, "R9 wrap", 32'(frame_cnt), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule